// File: doc/BRIEF.md
# TFT Raster Sync Timing Generator

This block produces the raster timing for a 320 by 240 colour TFT panel that is fed over a narrow parallel port. Depending on how the pixel is packed onto the port, one pixel occupies one, two or three port clocks, and a two-bit format code picks which. Every horizontal interval (line length, sync width, start and length of the active window) is scaled by that clocks-per-pixel figure, and the start of the active window is pushed later by a small per-format correction that covers the pipeline of the external packing logic.

The generator emits active-low line and frame syncs, a data-enable that marks the clocks carrying pixel data, the index of the current clock within its pixel, the pixel column and visible row, a one-clock frame-start marker and an error flag. A frame is 244 lines: two blanking lines, 240 visible lines, two more blanking lines. Timing starts when the enable input rises; a format code presented while the raster runs is adopted only at the next frame boundary. There is no data path, so all pins are plain control and status.

Top module: `lcd_sync_timing_gen`

## Requirements
- R1: After reset, and whenever the raster is not running, hsync_n and vsync_n are 1 and de, frame_start, pix_phase, x_pos and y_pos are 0.
- R2: Format code 0 gives 1 clock per pixel with correction 0, code 1 gives 2 clocks with correction 3, code 2 gives 3 clocks with correction 5; the code is taken at the clock edge where en is first seen high after being low.
- R3: A line lasts 336 × clocks-per-pixel clocks, and hsync_n is 0 during its first 2 × clocks-per-pixel clocks.
- R4: A frame has 244 lines; vsync_n is 0 during the first 2 × clocks-per-pixel clocks of line 0; frame_start is 1 for exactly the first clock of line 0, which is the clock right after the edge that starts the raster.
- R5: de is 1 on lines 2 to 241 only, from clock 7 × clocks-per-pixel + correction of the line for 320 × clocks-per-pixel clocks.
- R6: While de is 1, pix_phase counts 0 up to clocks-per-pixel − 1 within each pixel, x_pos counts pixels 0 to 319 and y_pos is the line number minus 2; all three are 0 while de is 0.
- R7: Starting with code 3, or reaching a frame boundary with code 3 presented, raises mode_err and holds all timing outputs inactive until en goes low.
- R8: A format code change while running takes effect from line 0 of the next frame, being sampled on the last clock of the current frame.
- R9: With en low, the next clock finds the raster stopped and mode_err cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run request; rising edge starts a frame |
| mode | input | 2 | Pixel format code (0, 1, 2 valid; 3 invalid) |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| de | output | 1 | Clock carries pixel data |
| pix_phase | output | 2 | Clock index within the current pixel |
| x_pos | output | 9 | Pixel column while de is high |
| y_pos | output | 8 | Visible row while de is high |
| frame_start | output | 1 | One-clock marker at the first clock of a frame |
| mode_err | output | 1 | Invalid format code seen |

## Verification
The assertions assume that en and mode are synchronous to clk and that reset is applied before the first run; they also assume the adopted format stays fixed inside a frame, which the design guarantees by loading it only at a boundary. The stimulus moves en, mode and rst_n only on falling clock edges, holds a valid code on mode across whole frames except where a change in mid-frame is the point of the test, and runs one complete frame so the frame wrap and the delayed format change are both seen.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    PM_WIDE565   = 2'd0,
    PM_NARROW565 = 2'd1,
    PM_NARROW888 = 2'd2,
    PM_INVALID   = 2'd3
  } pix_mode_e;

  function automatic logic [1:0] clks_per_pix(pix_mode_e m);
    case (m)
      PM_NARROW565: return 2'd2;
      PM_NARROW888: return 2'd3;
      default:      return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcdt_mode_ctrl.sv
module lcdt_mode_ctrl
  import lcdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  pix_mode_e mode_in,
  input  logic      frame_end,
  output logic      run,
  output logic      err,
  output pix_mode_e cur_mode,
  output logic      clr
);

  logic en_q;
  logic rise;

  assign rise = en & ~en_q;
  assign clr  = ~run | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      run      <= 1'b0;
      err      <= 1'b0;
      cur_mode <= PM_WIDE565;
    end else begin
      en_q <= en;
      if (!en) begin
        run <= 1'b0;
        err <= 1'b0;
      end else if (rise) begin
        if (mode_in == PM_INVALID) begin
          err <= 1'b1;
          run <= 1'b0;
        end else begin
          run      <= 1'b1;
          cur_mode <= mode_in;
        end
      end else if (run && frame_end) begin
        if (mode_in == PM_INVALID) begin
          run <= 1'b0;
          err <= 1'b1;
        end else begin
          cur_mode <= mode_in;
        end
      end
    end
  end

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !run); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> $stable(cur_mode)); // R8

  AST_STOP_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run && !err)); // R9

endmodule

// File: rtl/lcdt_raster_cnt.sv
module lcdt_raster_cnt #(
  parameter int H_TOTAL_PIX = 336,
  parameter int V_TOTAL     = 244,
  parameter int HCW         = 10,
  parameter int LCW         = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [1:0]     cpp,
  output logic [HCW-1:0] hcnt,
  output logic [LCW-1:0] lcnt,
  output logic           frame_end
);

  localparam logic [HCW-1:0] HP1 = HCW'(H_TOTAL_PIX);
  localparam logic [HCW-1:0] HP2 = HCW'(2 * H_TOTAL_PIX);
  localparam logic [HCW-1:0] HP3 = HCW'(3 * H_TOTAL_PIX);
  localparam logic [LCW-1:0] LAST_LINE = LCW'(V_TOTAL - 1);

  logic [HCW-1:0] hper;
  logic           line_end;

  always_comb begin
    case (cpp)
      2'd2:    hper = HP2;
      2'd3:    hper = HP3;
      default: hper = HP1;
    endcase
  end

  assign line_end  = (hcnt == hper - HCW'(1));
  assign frame_end = line_end && (lcnt == LAST_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      lcnt <= '0;
    end else if (clr) begin
      hcnt <= '0;
      lcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      lcnt <= frame_end ? '0 : lcnt + LCW'(1);
    end else begin
      hcnt <= hcnt + HCW'(1);
    end
  end

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (hcnt < hper)); // R3

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !clr) |=> (hcnt == '0)); // R3

  AST_L_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt <= LAST_LINE); // R4

endmodule

// File: rtl/lcdt_sync_decode.sv
module lcdt_sync_decode
  import lcdt_pkg::*;
#(
  parameter int H_ACTIVE   = 320,
  parameter int HS_PIX     = 2,
  parameter int HSTART_PIX = 7,
  parameter int V_TOP      = 2,
  parameter int V_ACTIVE   = 240,
  parameter int CORR_WIDE  = 0,
  parameter int CORR_N565  = 3,
  parameter int CORR_N888  = 5,
  parameter int HCW        = 10,
  parameter int LCW        = 8,
  parameter int XW         = 9,
  parameter int YW         = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  pix_mode_e      cur_mode,
  input  logic [HCW-1:0] hcnt,
  input  logic [LCW-1:0] lcnt,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           de,
  output logic [1:0]     pix_phase,
  output logic [XW-1:0]  x_pos,
  output logic [YW-1:0]  y_pos,
  output logic           frame_start
);

  localparam logic [LCW-1:0] VIS_FIRST = LCW'(V_TOP);
  localparam logic [LCW-1:0] VIS_END   = LCW'(V_TOP + V_ACTIVE);

  logic [1:0]     cpp;
  logic [HCW-1:0] cppw;
  logic [HCW-1:0] corr;
  logic [HCW-1:0] hs_w;
  logic [HCW-1:0] hstart;
  logic [HCW-1:0] hend;
  logic           in_pulse;
  logic           vis_line;
  logic           de_c;
  logic [1:0]     ph_q;
  logic [XW-1:0]  x_q;

  assign cpp  = clks_per_pix(cur_mode);
  assign cppw = HCW'(cpp);

  always_comb begin
    case (cur_mode)
      PM_NARROW565: corr = HCW'(CORR_N565);
      PM_NARROW888: corr = HCW'(CORR_N888);
      default:      corr = HCW'(CORR_WIDE);
    endcase
  end

  assign hs_w   = HCW'(HS_PIX) * cppw;
  assign hstart = HCW'(HSTART_PIX) * cppw + corr;
  assign hend   = hstart + HCW'(H_ACTIVE) * cppw;

  assign in_pulse = hcnt < hs_w;
  assign vis_line = (lcnt >= VIS_FIRST) && (lcnt < VIS_END);
  assign de_c     = run && vis_line && (hcnt >= hstart) && (hcnt < hend);

  assign hsync_n     = ~(run && in_pulse);
  assign vsync_n     = ~(run && in_pulse && (lcnt == '0));
  assign frame_start = run && (hcnt == '0) && (lcnt == '0);
  assign de          = de_c;
  assign pix_phase   = de_c ? ph_q : 2'd0;
  assign x_pos       = de_c ? x_q : '0;
  assign y_pos       = de_c ? YW'(lcnt - VIS_FIRST) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
      x_q  <= '0;
    end else if (de_c) begin
      if (ph_q == cpp - 2'd1) begin
        ph_q <= 2'd0;
        x_q  <= x_q + XW'(1);
      end else begin
        ph_q <= ph_q + 2'd1;
      end
    end else begin
      ph_q <= 2'd0;
      x_q  <= '0;
    end
  end

  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync_n); // R5

  AST_FS_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!vsync_n && !hsync_n)); // R4

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_phase < cpp)); // R6

  AST_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (x_pos < XW'(H_ACTIVE))); // R6

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && (pix_phase == 2'd0)) |-> (x_pos == $past(x_pos) + XW'(1))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_n && vsync_n && !de && !frame_start)); // R1

endmodule

// File: rtl/lcd_sync_timing_gen.sv
module lcd_sync_timing_gen
  import lcdt_pkg::*;
#(
  parameter int H_ACTIVE    = 320,
  parameter int H_TOTAL_PIX = 336,
  parameter int HS_PIX      = 2,
  parameter int HSTART_PIX  = 7,
  parameter int V_ACTIVE    = 240,
  parameter int V_TOP       = 2,
  parameter int V_BOTTOM    = 2,
  parameter int CORR_WIDE   = 0,
  parameter int CORR_N565   = 3,
  parameter int CORR_N888   = 5,
  localparam int V_TOTAL    = V_TOP + V_ACTIVE + V_BOTTOM,
  localparam int HCW        = $clog2(3 * H_TOTAL_PIX),
  localparam int LCW        = $clog2(V_TOTAL),
  localparam int XW         = $clog2(H_ACTIVE + 1),
  localparam int YW         = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic [1:0]    pix_phase,
  output logic [XW-1:0] x_pos,
  output logic [YW-1:0] y_pos,
  output logic          frame_start,
  output logic          mode_err
);

  logic           run;
  logic           clr;
  logic           frame_end;
  pix_mode_e      cur_mode;
  logic [HCW-1:0] hcnt;
  logic [LCW-1:0] lcnt;

  lcdt_mode_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode_in   (pix_mode_e'(mode)),
    .frame_end (frame_end),
    .run       (run),
    .err       (mode_err),
    .cur_mode  (cur_mode),
    .clr       (clr)
  );

  lcdt_raster_cnt #(
    .H_TOTAL_PIX (H_TOTAL_PIX),
    .V_TOTAL     (V_TOTAL),
    .HCW         (HCW),
    .LCW         (LCW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .cpp       (clks_per_pix(cur_mode)),
    .hcnt      (hcnt),
    .lcnt      (lcnt),
    .frame_end (frame_end)
  );

  lcdt_sync_decode #(
    .H_ACTIVE   (H_ACTIVE),
    .HS_PIX     (HS_PIX),
    .HSTART_PIX (HSTART_PIX),
    .V_TOP      (V_TOP),
    .V_ACTIVE   (V_ACTIVE),
    .CORR_WIDE  (CORR_WIDE),
    .CORR_N565  (CORR_N565),
    .CORR_N888  (CORR_N888),
    .HCW        (HCW),
    .LCW        (LCW),
    .XW         (XW),
    .YW         (YW)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cur_mode    (cur_mode),
    .hcnt        (hcnt),
    .lcnt        (lcnt),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .de          (de),
    .pix_phase   (pix_phase),
    .x_pos       (x_pos),
    .y_pos       (y_pos),
    .frame_start (frame_start)
  );

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (hsync_n && vsync_n && !de)); // R7

endmodule

// File: tb/lcd_sync_timing_gen_tb.sv
module lcd_sync_timing_gen_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       hsync_n, vsync_n, de, frame_start, mode_err;
  logic [1:0] pix_phase;
  logic [8:0] x_pos;
  logic [7:0] y_pos;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    bit    hs;
    bit    vs;
    bit    de;
    bit    fs;
    bit    err;
    int    ph;
    int    x;
    int    y;
    string tag;
  } exp_t;

  exp_t q[$];

  // reference state built from the requirements
  bit m_run = 0, m_err = 0, m_en = 0;
  int m_mode = 0, m_h = 0, m_l = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_sync_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pix_phase(pix_phase),
    .x_pos(x_pos), .y_pos(y_pos), .frame_start(frame_start), .mode_err(mode_err)
  );

  function automatic int cpp_of(int m);
    return (m == 1) ? 2 : (m == 2) ? 3 : 1;  // R2
  endfunction

  function automatic int corr_of(int m);
    return (m == 1) ? 3 : (m == 2) ? 5 : 0;  // R2
  endfunction

  task automatic check(string req, string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, tag, $time, act, expv);
    end
  endtask

  // driver: sets inputs at the falling edge and queues what must appear after the next rising edge
  task automatic cyc(bit r, bit e, int m, string tag);
    exp_t it;
    int c, hs0, hend;
    @(negedge clk);
    rst_n = r;
    en    = e;
    mode  = 2'(m);
    if (!r) begin
      m_run = 0; m_err = 0; m_h = 0; m_l = 0; m_mode = 0;
    end else if (!e) begin
      m_run = 0; m_err = 0; m_h = 0; m_l = 0;           // R9
    end else if (!m_en) begin
      if (m == 3) begin m_err = 1; m_run = 0; end       // R7
      else begin m_run = 1; m_mode = m; end             // R2
      m_h = 0; m_l = 0;
    end else if (m_run) begin
      if (m_h == 336 * cpp_of(m_mode) - 1) begin        // R3
        m_h = 0;
        if (m_l == 243) begin                           // R4
          m_l = 0;
          if (m == 3) begin m_run = 0; m_err = 1; end
          else m_mode = m;                              // R8
        end else m_l++;
      end else m_h++;
    end
    m_en = r ? e : 1'b0;
    c    = cpp_of(m_mode);
    hs0  = 7 * c + corr_of(m_mode);
    hend = hs0 + 320 * c;
    it.hs  = !(m_run && m_h < 2 * c);
    it.vs  = !(m_run && m_h < 2 * c && m_l == 0);
    it.fs  = m_run && m_h == 0 && m_l == 0;
    it.de  = m_run && m_l >= 2 && m_l <= 241 && m_h >= hs0 && m_h < hend;
    it.ph  = it.de ? (m_h - hs0) % c : 0;
    it.x   = it.de ? (m_h - hs0) / c : 0;
    it.y   = it.de ? m_l - 2 : 0;
    it.err = m_err;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t it;
    #(CLK_P/4);
    if (q.size() > 0) begin
      it = q.pop_front();
      check("R3", it.tag, int'(hsync_n), int'(it.hs));
      check("R4", it.tag, int'(vsync_n), int'(it.vs));
      check("R4", it.tag, int'(frame_start), int'(it.fs));
      check("R5", it.tag, int'(de), int'(it.de));
      check("R6", it.tag, int'(pix_phase), it.ph);
      check("R6", it.tag, int'(x_pos), it.x);
      check("R6", it.tag, int'(y_pos), it.y);
      check("R7", it.tag, int'(mode_err), int'(it.err));
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stimulus
    // R1: reset and idle
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R1 reset");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, "R1 idle");
    // R2 code 0 full frame; R8 code 1 presented mid-frame must wait for the wrap
    for (int i = 0; i < 336 * 3; i++) cyc(1, 1, 0, "R2 code0 start");
    for (int i = 0; i < 336 * 241; i++) cyc(1, 1, 1, "R8 code1 pending");
    for (int i = 0; i < 672 * 4; i++) cyc(1, 1, 1, "R8 code1 adopted");
    // R9 stop then R2 code 2
    for (int i = 0; i < 3; i++) cyc(1, 0, 2, "R9 stopped");
    for (int i = 0; i < 1008 * 3 + 50; i++) cyc(1, 1, 2, "R2 code2 run");
    // R7 invalid code at start
    for (int i = 0; i < 2; i++) cyc(1, 0, 3, "R9 stop again");
    for (int i = 0; i < 20; i++) cyc(1, 1, 3, "R7 invalid held");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R9 error cleared");
    repeat (2) @(posedge clk);
    #(CLK_P/2);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule